// File: doc/BRIEF.md
# Register-to-Line Link Table

This block tracks which architectural pointer registers currently hold an address that falls inside a line of the instruction prefetch buffer. While at least one register refers to a line, that line is kept resident. Two kinds of event create a link. A prefetch hint names a register and the buffer line chosen for the hinted address. A taken jump that saves its return address names the destination register and links it to the line the sequential path would have used: the line currently being fetched from, or the line that follows it. Register writes break links. They come as a bit mask, so one instruction that writes several registers clears all of their links in the same cycle.

Each register stores one line pointer. The all-ones value means the register is unlinked. Each line keeps a count of the registers that point at it. `line_held` shows which lines must stay resident: any line with a nonzero count, plus the current and next lines, which the fetch unit always holds. `line_release` pulses for one cycle when a line's count falls to zero while that line is neither current nor next. The replacement logic can then reclaim it. `lk_reg`/`lk_line` is a combinational lookup. The line buffer uses it to find the line for a register, for example before a jump through that register. No event interface applies back-pressure. Every event is accepted in the cycle it is presented.

Top module: `reg_line_link`

## Requirements
- R1: During and after a synchronous active-low reset, every register pointer reads all-ones (15 with the default 8 lines, 4-bit pointers). Every line count is zero, and `line_release` is all zero.
- R2: A prefetch hint (`hint_valid`) links `hint_reg` to line `hint_line`. From the cycle after the event edge, `lk_line` for that register returns `hint_line`.
- R3: A linking jump (`jal_valid`) links `jal_reg` to `cur_line` when `jal_use_next` is 0, and to `nxt_line` when it is 1, using the values sampled at the event edge.
- R4: A set bit `i` in `wr_mask` returns register `i`'s pointer to all-ones at that edge, unless a link to register `i` is made at the same edge.
- R5: Any number of `wr_mask` bits may be set in one cycle. All the named registers are unlinked at the same edge, and every line count drops by the number of its links that were broken.
- R6: Priority on one register at one edge, highest first: jump link, then prefetch hint, then write. A link made together with a write to the same register survives.
- R7: Linking an already linked register to a different line moves that register's reference from the old line to the new one.
- R8: Bit `l` of `line_held` is 1 exactly when line `l` has at least one register link, or equals `cur_line`, or equals `nxt_line`.
- R9: Bit `l` of `line_release` is 1 for exactly the one cycle after an edge that takes line `l`'s count from nonzero to zero, provided `l` is then neither `cur_line` nor `nxt_line`.
- R10: A write to a register that holds no link changes no count, no held bit and no release bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hint_valid | input | 1 | Prefetch hint event this cycle |
| hint_reg | input | REG_W (4) | Register named by the hint |
| hint_line | input | PTR_W (4) | Buffer line holding the hinted address |
| jal_valid | input | 1 | Taken jump saving its return address this cycle |
| jal_reg | input | REG_W (4) | Register receiving the return address |
| jal_use_next | input | 1 | 1: sequential path is in the next line; 0: in the current line |
| wr_mask | input | NUM_REGS (16) | One bit per register written this cycle |
| cur_line | input | PTR_W (4) | Line being fetched from (all-ones: none) |
| nxt_line | input | PTR_W (4) | Line prefetched after the current one (all-ones: none) |
| lk_reg | input | REG_W (4) | Register to look up |
| lk_line | output | PTR_W (4) | Line linked to `lk_reg`, all-ones if unlinked |
| line_held | output | NUM_LINES (8) | Lines that must stay resident |
| line_release | output | NUM_LINES (8) | One-cycle pulse: line lost its last link |

## Verification
Corrupted state shows at the ports. A bad register pointer appears on `lk_line` in the cycle after the faulty edge. A count that is off makes a `line_held` bit wrong from the cycle after the edge and stays wrong until a reset. It also either suppresses the release pulse for that line or raises it early. Errors in the priority order and in multi-write clearing show on the first lookup after the event that collides. The stimulus therefore reads back the register involved, together with the held and release masks, one cycle after every event. This covers shared lines, relinking, clearing several registers at once, and links that die while their line is current or next.

// File: rtl/rll_pkg.sv
package rll_pkg;
  // Which event sets a register pointer in a given cycle.
  typedef enum logic [1:0] {
    SRC_KEEP  = 2'd0,
    SRC_CLEAR = 2'd1,
    SRC_HINT  = 2'd2,
    SRC_JUMP  = 2'd3
  } link_src_e;
endpackage

// File: rtl/rll_ptr_array.sv
module rll_ptr_array
  import rll_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int NUM_LINES = 8,
  parameter int PTR_W     = 4,
  parameter int REG_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hint_valid,
  input  logic [REG_W-1:0] hint_reg,
  input  logic [PTR_W-1:0] hint_line,
  input  logic             jal_valid,
  input  logic [REG_W-1:0] jal_reg,
  input  logic             jal_use_next,
  input  logic [NUM_REGS-1:0] wr_mask,
  input  logic [PTR_W-1:0] cur_line,
  input  logic [PTR_W-1:0] nxt_line,
  output logic [PTR_W-1:0] ptr_q [NUM_REGS],
  output logic [PTR_W-1:0] ptr_d [NUM_REGS],
  output logic [NUM_REGS-1:0] ptr_chg
);
  localparam logic [PTR_W-1:0] NULL_PTR = '1;

  logic [PTR_W-1:0] jump_tgt;
  assign jump_tgt = jal_use_next ? nxt_line : cur_line;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    link_src_e src;

    always_comb begin
      if (jal_valid && (jal_reg == REG_W'(r)))        src = SRC_JUMP;
      else if (hint_valid && (hint_reg == REG_W'(r))) src = SRC_HINT;
      else if (wr_mask[r])                            src = SRC_CLEAR;
      else                                            src = SRC_KEEP;
    end

    always_comb begin
      unique case (src)
        SRC_JUMP:  ptr_d[r] = jump_tgt;
        SRC_HINT:  ptr_d[r] = hint_line;
        SRC_CLEAR: ptr_d[r] = NULL_PTR;
        default:   ptr_d[r] = ptr_q[r];
      endcase
    end

    assign ptr_chg[r] = (ptr_d[r] != ptr_q[r]);

    always_ff @(posedge clk) begin
      if (!rst_n) ptr_q[r] <= NULL_PTR;
      else        ptr_q[r] <= ptr_d[r];
    end

    AST_PTR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q[r] == NULL_PTR) || (ptr_q[r] < PTR_W'(NUM_LINES))); // R2

    AST_WRITE_BREAKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mask[r] && !(jal_valid && jal_reg == REG_W'(r))
                  && !(hint_valid && hint_reg == REG_W'(r)))
      |=> (ptr_q[r] == NULL_PTR)); // R4

    AST_LINK_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mask[r] && hint_valid && hint_reg == REG_W'(r)
                  && !(jal_valid && jal_reg == REG_W'(r)))
      |=> (ptr_q[r] == $past(hint_line))); // R6
  end

  AST_HINT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hint_valid |-> (hint_line < PTR_W'(NUM_LINES))); // R2

endmodule

// File: rtl/rll_line_ref.sv
module rll_line_ref #(
  parameter int NUM_REGS  = 16,
  parameter int NUM_LINES = 8,
  parameter int PTR_W     = 4,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] ptr_q [NUM_REGS],
  input  logic [PTR_W-1:0] ptr_d [NUM_REGS],
  input  logic [NUM_REGS-1:0] ptr_chg,
  output logic [NUM_LINES-1:0] cnt_zero,
  output logic [NUM_LINES-1:0] drop_q
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [CNT_W-1:0] cnt_q, cnt_d, inc, dec;

    always_comb begin
      inc = '0;
      dec = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
        if (ptr_chg[r] && (ptr_d[r] == PTR_W'(l))) inc = inc + CNT_W'(1);
        if (ptr_chg[r] && (ptr_q[r] == PTR_W'(l))) dec = dec + CNT_W'(1);
      end
      cnt_d = cnt_q + inc - dec;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q     <= '0;
        drop_q[l] <= 1'b0;
      end else begin
        cnt_q     <= cnt_d;
        drop_q[l] <= (cnt_q != '0) && (cnt_d == '0);
      end
    end

    assign cnt_zero[l] = (cnt_q == '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      dec <= cnt_q); // R7

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(NUM_REGS)); // R5
  end
endmodule

// File: rtl/rll_release.sv
module rll_release #(
  parameter int NUM_LINES = 8,
  parameter int PTR_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] cur_line,
  input  logic [PTR_W-1:0] nxt_line,
  input  logic [NUM_LINES-1:0] cnt_zero,
  input  logic [NUM_LINES-1:0] drop_q,
  output logic [NUM_LINES-1:0] line_held,
  output logic [NUM_LINES-1:0] line_release
);
  logic [NUM_LINES-1:0] fetch_hold;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_rel
    assign fetch_hold[l]   = (cur_line == PTR_W'(l)) || (nxt_line == PTR_W'(l));
    assign line_held[l]    = !cnt_zero[l] || fetch_hold[l];
    assign line_release[l] = drop_q[l] && !fetch_hold[l];

    AST_RELEASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      line_release[l] |=> !line_release[l]); // R9

    AST_RELEASE_UNLINKED: assert property (@(posedge clk) disable iff (!rst_n)
      line_release[l] |-> !line_held[l]); // R8
  end
endmodule

// File: rtl/reg_line_link.sv
module reg_line_link #(
  parameter int NUM_REGS  = 16,
  parameter int NUM_LINES = 8,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int PTR_W = $clog2(NUM_LINES + 1),
  localparam int CNT_W = $clog2(NUM_REGS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hint_valid,
  input  logic [REG_W-1:0]     hint_reg,
  input  logic [PTR_W-1:0]     hint_line,
  input  logic                 jal_valid,
  input  logic [REG_W-1:0]     jal_reg,
  input  logic                 jal_use_next,
  input  logic [NUM_REGS-1:0]  wr_mask,
  input  logic [PTR_W-1:0]     cur_line,
  input  logic [PTR_W-1:0]     nxt_line,
  input  logic [REG_W-1:0]     lk_reg,
  output logic [PTR_W-1:0]     lk_line,
  output logic [NUM_LINES-1:0] line_held,
  output logic [NUM_LINES-1:0] line_release
);
  logic [PTR_W-1:0]     ptr_q [NUM_REGS];
  logic [PTR_W-1:0]     ptr_d [NUM_REGS];
  logic [NUM_REGS-1:0]  ptr_chg;
  logic [NUM_LINES-1:0] cnt_zero;
  logic [NUM_LINES-1:0] drop_q;

  rll_ptr_array #(
    .NUM_REGS(NUM_REGS), .NUM_LINES(NUM_LINES), .PTR_W(PTR_W), .REG_W(REG_W)
  ) u_ptrs (
    .clk(clk), .rst_n(rst_n),
    .hint_valid(hint_valid), .hint_reg(hint_reg), .hint_line(hint_line),
    .jal_valid(jal_valid), .jal_reg(jal_reg), .jal_use_next(jal_use_next),
    .wr_mask(wr_mask), .cur_line(cur_line), .nxt_line(nxt_line),
    .ptr_q(ptr_q), .ptr_d(ptr_d), .ptr_chg(ptr_chg)
  );

  rll_line_ref #(
    .NUM_REGS(NUM_REGS), .NUM_LINES(NUM_LINES), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_refs (
    .clk(clk), .rst_n(rst_n),
    .ptr_q(ptr_q), .ptr_d(ptr_d), .ptr_chg(ptr_chg),
    .cnt_zero(cnt_zero), .drop_q(drop_q)
  );

  rll_release #(
    .NUM_LINES(NUM_LINES), .PTR_W(PTR_W)
  ) u_rel (
    .clk(clk), .rst_n(rst_n),
    .cur_line(cur_line), .nxt_line(nxt_line),
    .cnt_zero(cnt_zero), .drop_q(drop_q),
    .line_held(line_held), .line_release(line_release)
  );

  assign lk_line = ptr_q[lk_reg];

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(!rst_n) |-> (line_release == '0)); // R1
endmodule

// File: tb/reg_line_link_tb_top.sv
module reg_line_link_tb_top;
  localparam int NR = 16;
  localparam int NL = 8;
  localparam int NV = 15;

  typedef struct packed {
    logic       hv;  logic [3:0] hr;  logic [3:0] hl;
    logic       jv;  logic [3:0] jr;  logic       jn;
    logic [15:0] wm; logic [3:0] cur; logic [3:0] nxt;
    logic [3:0] lr;  logic [3:0] elk; logic [7:0] eheld; logic [7:0] erel;
  } vec_t;

  localparam logic [62:0] VEC [NV] = '{
    {1'b1,4'd2,4'd3,   1'b0,4'd0,1'b0, 16'h0000, 4'd0,4'd1, 4'd2,4'd3,   8'h0B,8'h00}, // R2
    {1'b1,4'd5,4'd3,   1'b0,4'd0,1'b0, 16'h0000, 4'd0,4'd1, 4'd5,4'd3,   8'h0B,8'h00}, // R2 shared line
    {1'b0,4'd0,4'd0,   1'b0,4'd0,1'b0, 16'h0004, 4'd0,4'd1, 4'd2,4'd15,  8'h0B,8'h00}, // R4
    {1'b0,4'd0,4'd0,   1'b0,4'd0,1'b0, 16'h0020, 4'd0,4'd1, 4'd5,4'd15,  8'h03,8'h08}, // R9
    {1'b0,4'd0,4'd0,   1'b1,4'd7,1'b0, 16'h0000, 4'd0,4'd1, 4'd7,4'd0,   8'h03,8'h00}, // R3 current
    {1'b0,4'd0,4'd0,   1'b1,4'd8,1'b1, 16'h0000, 4'd0,4'd1, 4'd8,4'd1,   8'h03,8'h00}, // R3 next
    {1'b1,4'd3,4'd6,   1'b0,4'd0,1'b0, 16'h0000, 4'd0,4'd1, 4'd3,4'd6,   8'h43,8'h00}, // R8
    {1'b0,4'd0,4'd0,   1'b1,4'd9,1'b0, 16'h0000, 4'd5,4'd6, 4'd9,4'd5,   8'h63,8'h00}, // R3 R8
    {1'b0,4'd0,4'd0,   1'b0,4'd0,1'b0, 16'h0388, 4'd2,4'd4, 4'd8,4'd15,  8'h14,8'h63}, // R5
    {1'b1,4'd1,4'd7,   1'b0,4'd0,1'b0, 16'h0002, 4'd2,4'd4, 4'd1,4'd7,   8'h94,8'h00}, // R6
    {1'b1,4'd1,4'd2,   1'b0,4'd0,1'b0, 16'h0000, 4'd2,4'd4, 4'd1,4'd2,   8'h14,8'h80}, // R7
    {1'b0,4'd0,4'd0,   1'b0,4'd0,1'b0, 16'h0002, 4'd2,4'd4, 4'd1,4'd15,  8'h14,8'h00}, // R9 held by fetch
    {1'b0,4'd0,4'd0,   1'b0,4'd0,1'b0, 16'h8001, 4'd2,4'd4, 4'd0,4'd15,  8'h14,8'h00}, // R10
    {1'b1,4'd6,4'd3,   1'b1,4'd6,1'b1, 16'h0000, 4'd2,4'd4, 4'd6,4'd4,   8'h14,8'h00}, // R6 jump beats hint
    {1'b1,4'd10,4'd0,  1'b0,4'd0,1'b0, 16'h0000, 4'd2,4'd4, 4'd10,4'd0,  8'h15,8'h00}  // R2 R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hint_valid = 1'b0, jal_valid = 1'b0, jal_use_next = 1'b0;
  logic [3:0] hint_reg = '0, hint_line = '0, jal_reg = '0;
  logic [15:0] wr_mask = '0;
  logic [3:0] cur_line = 4'd0, nxt_line = 4'd1, lk_reg = '0;
  logic [3:0] lk_line;
  logic [7:0] line_held, line_release;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  string vtag [NV];

  always #4 clk = ~clk;

  reg_line_link dut_i (
    .clk(clk), .rst_n(rst_n),
    .hint_valid(hint_valid), .hint_reg(hint_reg), .hint_line(hint_line),
    .jal_valid(jal_valid), .jal_reg(jal_reg), .jal_use_next(jal_use_next),
    .wr_mask(wr_mask), .cur_line(cur_line), .nxt_line(nxt_line),
    .lk_reg(lk_reg), .lk_line(lk_line),
    .line_held(line_held), .line_release(line_release)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle_events();
    hint_valid = 1'b0; jal_valid = 1'b0; jal_use_next = 1'b0;
    hint_reg = '0; hint_line = '0; jal_reg = '0; wr_mask = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    vtag = '{"R2", "R2", "R4", "R9", "R3", "R3", "R8", "R3", "R5",
             "R6", "R7", "R9", "R10", "R6", "R8"};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state while reset is asserted
    check("R1", "held in reset", 16'(line_held), 16'h0003);
    check("R1", "release in reset", 16'(line_release), 16'h0000);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    // R1: every pointer unlinked after reset
    for (int r = 0; r < NR; r++) begin
      lk_reg = 4'(r);
      #1 check("R1", "pointer after reset", 16'(lk_line), 16'h000F);
    end
    check("R1", "release after reset", 16'(line_release), 16'h0000);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VEC[i]);
      @(negedge clk);
      hint_valid = v.hv; hint_reg = v.hr; hint_line = v.hl;
      jal_valid = v.jv; jal_reg = v.jr; jal_use_next = v.jn;
      wr_mask = v.wm; cur_line = v.cur; nxt_line = v.nxt;
      @(posedge clk);
      #1;
      idle_events();
      lk_reg = v.lr;
      #1;
      check(vtag[i], $sformatf("vec %0d lookup", i), 16'(lk_line), 16'(v.elk));
      check(vtag[i], $sformatf("vec %0d held", i), 16'(line_held), 16'(v.eheld));
      check(vtag[i], $sformatf("vec %0d release", i), 16'(line_release), 16'(v.erel));
    end

    // R9: the release pulse is gone one cycle later
    @(negedge clk);
    check("R9", "release after idle cycle", 16'(line_release), 16'h0000);

    // R1: reset in mid-run drops every link
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    lk_reg = 4'd10;
    #1 check("R1", "pointer after second reset", 16'(lk_line), 16'h000F);
    check("R1", "held after second reset", 16'(line_held), 16'h0014);
    check("R1", "release after second reset", 16'(line_release), 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule